// File: doc/BRIEF.md
# Layered LDPC Decode Job Sequencer

This block runs one layered LDPC decoding job from start to finish. It first takes in an input frame, which arrives as a stream marked by start, end and valid flags. At the start beat it captures the code-rate selector, the block-length selector, the requested iteration count and the stop mode. It then starts one iteration at a time on an external functional unit. That unit reports the end of each layer together with a syndrome-ok flag, and signals the end of each iteration. The block ANDs the syndrome flags into a parity verdict for each iteration.

After the last iteration the block runs an output phase. The number of beats in that phase depends on the block-length selector. The block then shows the number of iterations it performed and the final parity verdict, and returns to the ready state.

A new frame start that arrives while the block is busy aborts the job in progress. A selector value of 3 marks the frame as undecodable. The check-node and variable-node arithmetic, and the message storage, are outside this block.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: The iteration limit is the requested count `iter_req_i` (8 bits) when that count is between 1 and 63. A request of 0, or of 64 and above, is replaced by a limit of 8. The limit is captured on the accepted start beat.
- R2: In fixed mode (`early_i`=0), exactly as many iterations run as the limit, whatever the parity results.
- R3: In early mode (`early_i`=1), decoding stops after the first iteration whose parity verdict passes. If no iteration passes, it stops after the limit is reached.
- R4: `parity_ok_o` shows the verdict of the final iteration. A verdict is the AND of the `fu_layer_ok_i` values on all `fu_layer_done_i` pulses of that iteration, and each iteration starts from a clean verdict.
- R5: `act_iter_o` is cleared to 0 when a frame start is accepted. It then counts up by one for each completed iteration.
- R6: After reset, `ready_o`=1, `act_iter_o`=0, `parity_ok_o`=0, and no output or kick is active. `ready_o` is 1 only while idle, and it is 0 from the cycle after an accepted start.
- R7: `in_start_i`&`in_valid_i` while `ready_o`=0 abandons the current job. That job produces no output beats, and the new frame is loaded and decoded in its place.
- R8: `rate_o` and `len_o` hold the selector values captured at the start beat. Changes on `rate_idx_i`, `len_idx_i`, `iter_req_i` and `early_i` after that beat have no effect on the job.
- R9: If either captured selector equals 3, the frame runs no iterations and produces no output beats. `act_iter_o` and `parity_ok_o` stay 0, and `ready_o` returns one cycle after the end beat.
- R10: The output phase lasts 1024·4^len/LANES beats, which is 128, 512 or 2048 beats for len 0, 1 or 2 with 8 lanes. `out_valid_o` is high on every beat, `out_start_o` on the first beat only, and `out_end_o` on the last beat only. `ready_o` is 1 in the cycle after `out_end_o`.
- R11: `fu_start_o` pulses for one cycle at the start of each iteration. The first pulse comes in the cycle after the end beat is accepted, and the number of pulses equals `act_iter_o`.
- R12: A layer report in the same cycle as the end of an iteration counts toward that iteration. A frame start in the same cycle as the end of the final iteration takes priority: there is no output phase and `act_iter_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_start_i | input | 1 | First beat of input frame |
| in_end_i | input | 1 | Last beat of input frame |
| in_valid_i | input | 1 | Input beat valid |
| rate_idx_i | input | 2 | Code rate selector (0: 1/2, 1: 2/3, 2: 4/5, 3: invalid) |
| len_idx_i | input | 2 | Block length selector (0: 1024, 1: 4096, 2: 16384, 3: invalid) |
| iter_req_i | input | 8 | Requested iteration count |
| early_i | input | 1 | 1: stop on first passing iteration |
| fu_layer_done_i | input | 1 | Functional unit finished a layer |
| fu_layer_ok_i | input | 1 | That layer's parity rows were satisfied |
| fu_iter_done_i | input | 1 | Functional unit finished the iteration |
| fu_start_o | output | 1 | Kick one iteration |
| rate_o | output | 2 | Captured rate selector |
| len_o | output | 2 | Captured length selector |
| out_start_o | output | 1 | First output beat |
| out_end_o | output | 1 | Last output beat |
| out_valid_o | output | 1 | Output beat valid |
| ready_o | output | 1 | Ready for the next frame start |
| act_iter_o | output | 6 | Iterations performed for this frame |
| parity_ok_o | output | 1 | Final parity verdict |

## Verification
A new frame start can arrive in the same cycle that the functional unit reports the end of the last iteration. In that cycle the abort path and the stop-and-emit path compete. The bench's functional-unit model provokes this by raising a start beat in exactly the cycle it drives the final iteration-done pulse. The outcome counts as correct when no output beat of the abandoned frame ever appears, the iteration count reads 0 one cycle later, and the replacement frame then decodes with its own count, verdict and beat length. The same model always reports the last layer in the iteration-done cycle, so a failing last layer in that cycle must also reach the verdict.

// File: rtl/ldpc_ctrl_pkg.sv
package ldpc_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_KICK = 3'd2,
    ST_RUN  = 3'd3,
    ST_OUT  = 3'd4
  } ctrl_state_e;

  localparam logic [1:0] IDX_BAD = 2'd3;
endpackage

// File: rtl/ldpc_iter_clamp.sv
module ldpc_iter_clamp #(
  parameter int REQ_W    = 8,
  parameter int ITER_W   = 6,
  parameter int MAX_ITER = 63,
  parameter int DEF_ITER = 8
) (
  input  logic [REQ_W-1:0]  req_i,
  output logic [ITER_W-1:0] limit_o
);
  always_comb begin
    if (req_i == '0 || int'(req_i) > MAX_ITER) limit_o = ITER_W'(DEF_ITER);
    else                                       limit_o = req_i[ITER_W-1:0];
  end
endmodule

// File: rtl/ldpc_parity_acc.sv
module ldpc_parity_acc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic layer_done_i,
  input  logic layer_ok_i,
  output logic verdict_o
);
  logic acc_q;

  // includes a layer report landing this cycle
  assign verdict_o = acc_q & ~(layer_done_i & ~layer_ok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= 1'b1;
    else if (clr_i) acc_q <= 1'b1;
    else            acc_q <= verdict_o;
  end
endmodule

// File: rtl/ldpc_out_seq.sv
module ldpc_out_seq #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] beats_i,
  output logic             start_o,
  output logic             valid_o,
  output logic             end_o
);
  logic             active_q, first_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      left_q   <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
    end else if (go_i) begin
      active_q <= 1'b1;
      first_q  <= 1'b1;
      left_q   <= beats_i - CNT_W'(1);
    end else if (active_q) begin
      first_q <= 1'b0;
      if (left_q == '0) active_q <= 1'b0;
      else              left_q   <= left_q - CNT_W'(1);
    end
  end

  assign valid_o = active_q;
  assign start_o = active_q & first_q;
  assign end_o   = active_q & (left_q == '0);
endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl
  import ldpc_ctrl_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int BASE_BITS = 1024,
  parameter int REQ_W     = 8,
  parameter int ITER_W    = 6,
  parameter int MAX_ITER  = 63,
  parameter int DEF_ITER  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_start_i,
  input  logic              in_end_i,
  input  logic              in_valid_i,
  input  logic [1:0]        rate_idx_i,
  input  logic [1:0]        len_idx_i,
  input  logic [REQ_W-1:0]  iter_req_i,
  input  logic              early_i,
  input  logic              fu_layer_done_i,
  input  logic              fu_layer_ok_i,
  input  logic              fu_iter_done_i,
  output logic              fu_start_o,
  output logic [1:0]        rate_o,
  output logic [1:0]        len_o,
  output logic              out_start_o,
  output logic              out_end_o,
  output logic              out_valid_o,
  output logic              ready_o,
  output logic [ITER_W-1:0] act_iter_o,
  output logic              parity_ok_o
);
  localparam int MIN_BEATS = BASE_BITS / LANES;
  localparam int MAX_BEATS = MIN_BEATS * 16;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  ctrl_state_e       state_q;
  logic [1:0]        rate_q, len_q;
  logic [ITER_W-1:0] limit_q, limit_d, iter_q, iter_nx;
  logic              early_q, bad_q, par_q;
  logic              take_start, bad_d, in_run, verdict, stop, go_out;
  logic              seq_end;
  logic [CNT_W-1:0]  beats;

  ldpc_iter_clamp #(
    .REQ_W(REQ_W), .ITER_W(ITER_W), .MAX_ITER(MAX_ITER), .DEF_ITER(DEF_ITER)
  ) u_clamp (
    .req_i   (iter_req_i),
    .limit_o (limit_d)
  );

  assign in_run = (state_q == ST_RUN);

  ldpc_parity_acc u_par (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (state_q == ST_KICK),
    .layer_done_i (fu_layer_done_i & in_run),
    .layer_ok_i   (fu_layer_ok_i),
    .verdict_o    (verdict)
  );

  always_comb begin
    case (len_q)
      2'd0:    beats = CNT_W'(MIN_BEATS);
      2'd1:    beats = CNT_W'(MIN_BEATS * 4);
      default: beats = CNT_W'(MIN_BEATS * 16);
    endcase
  end

  assign take_start = in_start_i & in_valid_i;
  assign bad_d      = (rate_idx_i == IDX_BAD) | (len_idx_i == IDX_BAD);
  assign iter_nx    = iter_q + ITER_W'(1);
  assign stop       = (early_q & verdict) | (iter_nx == limit_q);
  assign go_out     = in_run & fu_iter_done_i & stop & ~take_start;

  ldpc_out_seq #(.CNT_W(CNT_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go_out),
    .abort_i (take_start),
    .beats_i (beats),
    .start_o (out_start_o),
    .valid_o (out_valid_o),
    .end_o   (seq_end)
  );
  assign out_end_o = seq_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rate_q  <= '0;
      len_q   <= '0;
      limit_q <= ITER_W'(DEF_ITER);
      early_q <= 1'b0;
      bad_q   <= 1'b0;
      iter_q  <= '0;
      par_q   <= 1'b0;
    end else if (take_start) begin
      // accepted in any state; aborts a job in flight
      rate_q  <= rate_idx_i;
      len_q   <= len_idx_i;
      limit_q <= limit_d;
      early_q <= early_i;
      bad_q   <= bad_d;
      iter_q  <= '0;
      par_q   <= 1'b0;
      if (in_end_i) state_q <= bad_d ? ST_IDLE : ST_KICK;
      else          state_q <= ST_LOAD;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_LOAD: if (in_valid_i && in_end_i) state_q <= bad_q ? ST_IDLE : ST_KICK;
        ST_KICK: state_q <= ST_RUN;
        ST_RUN: if (fu_iter_done_i) begin
          iter_q  <= iter_nx;
          par_q   <= verdict;
          state_q <= stop ? ST_OUT : ST_KICK;
        end
        ST_OUT: if (seq_end) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fu_start_o  = (state_q == ST_KICK);
  assign ready_o     = (state_q == ST_IDLE);
  assign rate_o      = rate_q;
  assign len_o       = len_q;
  assign act_iter_o  = iter_q;
  assign parity_ok_o = par_q;
endmodule

// File: rtl/ldpc_iter_ctrl_chk.sv
module ldpc_iter_ctrl_chk
  import ldpc_ctrl_pkg::*;
#(
  parameter int ITER_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_start_i,
  input logic              in_end_i,
  input logic              in_valid_i,
  input logic              fu_iter_done_i,
  input logic              fu_start_o,
  input logic              out_start_o,
  input logic              out_end_o,
  input logic              out_valid_o,
  input logic              ready_o,
  input logic [ITER_W-1:0] act_iter_o,
  input logic              parity_ok_o,
  input ctrl_state_e       state_q,
  input logic [ITER_W-1:0] limit_q,
  input logic              early_q
);
  AST_FIXED_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_start_o && !early_q |-> act_iter_o == limit_q); // R2

  AST_EARLY_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_start_o && early_q && act_iter_o != limit_q |-> parity_ok_o); // R3

  AST_ITER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && fu_iter_done_i && !(in_start_i && in_valid_i)
    |=> act_iter_o == $past(act_iter_o) + 1'b1); // R5

  AST_NO_KICK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !fu_start_o && !out_valid_o); // R6

  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_start_i && in_valid_i && !in_end_i |=> !ready_o && act_iter_o == '0 && !out_valid_o); // R7

  AST_OUT_FRAMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_start_o || out_end_o) |-> out_valid_o); // R10

  AST_READY_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_end_o && !(in_start_i && in_valid_i) |=> ready_o); // R10

  AST_KICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fu_start_o && !(in_start_i && in_valid_i) |=> !fu_start_o); // R11
endmodule

bind ldpc_iter_ctrl ldpc_iter_ctrl_chk #(.ITER_W(ITER_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_start_i     (in_start_i),
  .in_end_i       (in_end_i),
  .in_valid_i     (in_valid_i),
  .fu_iter_done_i (fu_iter_done_i),
  .fu_start_o     (fu_start_o),
  .out_start_o    (out_start_o),
  .out_end_o      (out_end_o),
  .out_valid_o    (out_valid_o),
  .ready_o        (ready_o),
  .act_iter_o     (act_iter_o),
  .parity_ok_o    (parity_ok_o),
  .state_q        (state_q),
  .limit_q        (limit_q),
  .early_q        (early_q)
);

// File: tb/ldpc_iter_ctrl_test.sv
module ldpc_iter_ctrl_test;
  localparam int LAYERS = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tb_start = 1'b0, tb_end = 1'b0, tb_valid = 1'b0;
  logic       abort_pulse = 1'b0;
  logic [1:0] rate_idx_i = '0, len_idx_i = '0;
  logic [7:0] iter_req_i = '0;
  logic       early_i = 1'b0;
  logic       fu_layer_done_i = 1'b0, fu_layer_ok_i = 1'b0, fu_iter_done_i = 1'b0;
  logic       fu_start_o, out_start_o, out_end_o, out_valid_o, ready_o, parity_ok_o;
  logic [1:0] rate_o, len_o;
  logic [5:0] act_iter_o;
  logic       in_start_i, in_valid_i;

  assign in_start_i = tb_start | abort_pulse;
  assign in_valid_i = tb_valid | abort_pulse;

  always #5 clk_i = ~clk_i;

  ldpc_iter_ctrl uut (
    .clk_i, .rst_ni, .in_start_i, .in_end_i(tb_end), .in_valid_i,
    .rate_idx_i, .len_idx_i, .iter_req_i, .early_i,
    .fu_layer_done_i, .fu_layer_ok_i, .fu_iter_done_i,
    .fu_start_o, .rate_o, .len_o, .out_start_o, .out_end_o, .out_valid_o,
    .ready_o, .act_iter_o, .parity_ok_o
  );

  int n_chk = 0, n_bad = 0;
  logic [63:0] pass_mask = '0;
  bit  abort_arm = 0, abort_fired = 0;
  int  abort_at = 0;

  // functional unit model: 3 layers, 2 cycles each; layer 1 fails when iteration is marked failing
  bit busy = 0;
  int layer = 0, tmr = 0;
  always @(negedge clk_i) begin
    fu_layer_done_i = 1'b0; fu_layer_ok_i = 1'b0; fu_iter_done_i = 1'b0; abort_pulse = 1'b0;
    if (!rst_ni) busy = 0;
    else if (fu_start_o) begin busy = 1; layer = 0; tmr = 2; end
    else if (busy) begin
      tmr = tmr - 1;
      if (tmr == 0) begin
        fu_layer_done_i = 1'b1;
        fu_layer_ok_i = pass_mask[act_iter_o] | (layer != 1);
        if (layer == LAYERS - 1) begin
          fu_iter_done_i = 1'b1;
          busy = 0;
          if (abort_arm && int'(act_iter_o) == abort_at) begin
            abort_pulse = 1'b1; abort_arm = 0; abort_fired = 1;
          end
        end else begin
          layer = layer + 1; tmr = 2;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_frame(logic [1:0] rate, logic [1:0] len, logic [7:0] req, bit early, int n);
    @(negedge clk_i);
    rate_idx_i = rate; len_idx_i = len; iter_req_i = req; early_i = early;
    for (int i = 0; i < n; i++) begin
      tb_valid = 1'b1; tb_start = (i == 0); tb_end = (i == n - 1);
      @(negedge clk_i);
      if (i == 0) begin
        chk(ready_o == 1'b0, "R6 ready low while loading", int'(ready_o), 0);
        rate_idx_i = 2'd3; len_idx_i = 2'd3; iter_req_i = 8'd0; early_i = ~early;
      end
    end
    tb_valid = 1'b0; tb_start = 1'b0; tb_end = 1'b0;
  endtask

  task automatic monitor(string tag, int er, int el, int eact, int epar, int ebeats);
    int beats = 0, kicks = 0, sp = -1, ep = -1;
    bit prev_end = 0, rdy_after = 0, done = 0;
    for (int cyc = 0; cyc < 60000 && !done; cyc++) begin
      if (prev_end) rdy_after = ready_o;
      prev_end = 0;
      if (ready_o) done = 1;
      else begin
        kicks += int'(fu_start_o);
        if (out_valid_o) begin
          if (out_start_o) begin if (sp < 0) sp = beats; else sp = -2; end
          if (out_end_o) begin ep = beats; prev_end = 1; end
          beats++;
        end
        @(negedge clk_i);
      end
    end
    chk(done, {tag, " R6 ready returns"}, int'(done), 1);
    chk(beats == ebeats, {tag, " R10 beat count"}, beats, ebeats);
    if (ebeats > 0) begin
      chk(sp == 0, {tag, " R10 start on first beat"}, sp, 0);
      chk(ep == ebeats - 1, {tag, " R10 end on last beat"}, ep, ebeats - 1);
      chk(rdy_after, {tag, " R10 ready after end"}, int'(rdy_after), 1);
    end
    chk(int'(act_iter_o) == eact, {tag, " R5 act_iter"}, int'(act_iter_o), eact);
    chk(int'(parity_ok_o) == epar, {tag, " R4 parity"}, int'(parity_ok_o), epar);
    chk(kicks == eact, {tag, " R11 kick count"}, kicks, eact);
    chk(int'(rate_o) == er && int'(len_o) == el, {tag, " R8 latched idx"},
        int'({rate_o, len_o}), (er << 2) | el);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(ready_o && act_iter_o == 0 && !parity_ok_o && !out_valid_o && !fu_start_o,
        "R6 reset state", int'({ready_o, parity_ok_o, out_valid_o, fu_start_o}), 8);
  endtask

  task automatic t_fixed();
    pass_mask = '0;
    send_frame(2'd0, 2'd0, 8'd5, 1'b0, 4); monitor("R2 fixed5 fail", 0, 0, 5, 0, 128);
    pass_mask = '1;
    send_frame(2'd1, 2'd2, 8'd1, 1'b0, 3); monitor("R2 fixed1 len2", 1, 2, 1, 1, 2048);
  endtask

  task automatic t_clamp();
    pass_mask = '0;
    send_frame(2'd2, 2'd0, 8'd0, 1'b0, 2);   monitor("R1 req0", 2, 0, 8, 0, 128);
    send_frame(2'd0, 2'd0, 8'd200, 1'b0, 2); monitor("R1 req200", 0, 0, 8, 0, 128);
    send_frame(2'd0, 2'd0, 8'd64, 1'b0, 2);  monitor("R1 req64", 0, 0, 8, 0, 128);
    pass_mask = '1;
    send_frame(2'd0, 2'd1, 8'd63, 1'b0, 2);  monitor("R1 req63", 0, 1, 63, 1, 512);
  endtask

  task automatic t_early();
    pass_mask = 64'h4;
    send_frame(2'd0, 2'd0, 8'd10, 1'b1, 2); monitor("R3 early pass3", 0, 0, 3, 1, 128);
    pass_mask = 64'h1;
    send_frame(2'd1, 2'd0, 8'd10, 1'b1, 2); monitor("R3 early pass1", 1, 0, 1, 1, 128);
    pass_mask = '0;
    send_frame(2'd2, 2'd0, 8'd4, 1'b1, 2);  monitor("R3 early limit", 2, 0, 4, 0, 128);
  endtask

  task automatic t_parity();
    pass_mask = 64'h3;
    send_frame(2'd0, 2'd0, 8'd3, 1'b0, 2); monitor("R4 last fails", 0, 0, 3, 0, 128);
    pass_mask = 64'h4;
    send_frame(2'd0, 2'd0, 8'd3, 1'b0, 2); monitor("R4 fresh verdict R12", 0, 0, 3, 1, 128);
  endtask

  task automatic t_bad();
    pass_mask = '1;
    send_frame(2'd0, 2'd0, 8'd2, 1'b0, 2); monitor("R9 prior", 0, 0, 2, 1, 128);
    send_frame(2'd3, 2'd0, 8'd2, 1'b0, 3); monitor("R9 rate3", 3, 0, 0, 0, 0);
    send_frame(2'd1, 2'd3, 8'd2, 1'b0, 3); monitor("R9 len3", 1, 3, 0, 0, 0);
  endtask

  task automatic t_abort();
    int guard = 0;
    pass_mask = '0;
    send_frame(2'd0, 2'd0, 8'd10, 1'b0, 2);
    while (act_iter_o != 6'd2 && guard < 1000) begin @(negedge clk_i); guard++; end
    chk(ready_o == 1'b0, "R7 busy before abort", int'(ready_o), 0);
    pass_mask = '1;
    send_frame(2'd1, 2'd1, 8'd2, 1'b0, 10); monitor("R7 replacement", 1, 1, 2, 1, 512);
  endtask

  task automatic t_conflict();
    int guard = 0;
    pass_mask = '0;
    abort_at = 2; abort_fired = 0; abort_arm = 1;
    send_frame(2'd0, 2'd0, 8'd3, 1'b0, 2);
    rate_idx_i = 2'd2; len_idx_i = 2'd0; iter_req_i = 8'd4; early_i = 1'b1;
    pass_mask = 64'h2;
    while (!abort_fired && guard < 1000) begin @(posedge clk_i); guard++; end
    @(negedge clk_i);
    chk(abort_fired && !ready_o && act_iter_o == 0 && !out_valid_o,
        "R12 abort beats final iteration", int'(act_iter_o), 0);
    for (int i = 0; i < 4; i++) begin
      tb_valid = 1'b1; tb_end = (i == 3);
      @(negedge clk_i);
    end
    tb_valid = 1'b0; tb_end = 1'b0;
    monitor("R12 new frame after conflict", 2, 0, 2, 1, 128);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(10 * 150000);
    n_bad++;
    $display("FAIL R6 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_fixed();
    t_clamp();
    t_early();
    t_parity();
    t_bad();
    t_abort();
    t_conflict();
    summary();
    $finish;
  end
endmodule